// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This block is a bus-attached coprocessor that turns one 8x8 block of signed 8-bit samples into 64 signed 8-bit two-dimensional forward DCT coefficients. It uses integer fixed-point arithmetic only. Software writes the 64 samples one after another into a data-in register. It then writes 1 to a command register and polls a status register until the done flag is set. Finally it reads the 64 coefficients one after another from a data-out register. Samples and coefficients both travel in row-major order.

Each coefficient is F(u,v) = 1/4 · C(u) · C(v) · sum over x,y of D(x,y) · cos((2x+1)uπ/16) · cos((2y+1)vπ/16). C(0) is 1/√2 and C(h) is 1 for h > 0. The cosine factors come from a computed table of 8-bit entries with 6 fractional bits, and every fixed-point product is shifted right by 6. The datapath does one multiply-accumulate per clock, so one block takes 4096 busy cycles. The scale factors and output saturation are applied in the cycle that finishes each coefficient.

Top module: `fdct_copro`

## Requirements
- R1: After reset the status register reads 0 (bit 0 done = 0, bit 1 busy = 0) and bus_rdata is 0.
- R2: Register offsets are 0 data-in (write), 1 data-out (read), 2 command (write), 3 status (read; bit 0 done, bit 1 busy, other bits 0). A read issued with bus_rd in one cycle shows on bus_rdata in the next cycle and holds until the next read. Reads of offsets 0 and 2 return 0. Busy and done are never both 1.
- R3: Each data-in write stores the signed sample at the push position and advances it. Position p = 8·x + y holds D(x,y). The push position wraps from 63 back to 0, so a 65th write overwrites D(0,0).
- R4: A command write with bit 0 = 1 while not busy starts a transform. It sets busy, clears done and resets the push and pop positions to 0. A command write with bit 0 = 0, or any command write while busy, has no effect.
- R5: The cosine factor for spatial index s and frequency f is round(64·cos(k·π/16)) with k = (2s+1)·f, taken from the table 64, 63, 59, 53, 45, 36, 24, 12, 0 for k = 0..8 and extended by cosine symmetry over k mod 32.
- R6: Each of the 64 terms of a coefficient is ((D(x,y)·cos_xu) >>> 6)·cos_yv >>> 6. The shifts are arithmetic (floor), and the terms are summed in a signed accumulator of at least 24 bits.
- R7: If u = 0 the sum is replaced by (sum·45) >>> 6. Then, if v = 0, the result is replaced by (value·45) >>> 6. The value is then shifted right arithmetically by 2.
- R8: The scaled value is clamped to [-128, 127] before it is stored as the 8-bit coefficient.
- R9: Busy stays 1 for exactly 4096 clock cycles, starting with the edge that takes the command. Busy then falls and done rises in the same cycle.
- R10: Data-in writes while busy are ignored: the stored samples and the push position are unchanged.
- R11: Data-out reads return coefficients in row-major order, position 8·u + v. A new command resets the read position to 0, and a command with no new pushes transforms the retained samples again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (2) | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data, valid the cycle after bus_rd |

## Verification
The bench compares every coefficient with an integer model built from floating-point cosines. A wrong table entry, a missing floor shift or a scale applied on the wrong axis therefore shows up as a mismatch. Constant blocks at +127 and -128 drive the DC term far past the 8-bit range, so a design without clamping would return a wrapped value there. The status register is sampled at the exact 4096-cycle boundary. During the run the bench writes a second command and some stray samples; a design that restarted or accepted them would finish late or return coefficients of a corrupted block. The bench also checks the wrap of the push position, that a zero command has no effect, and that a re-issued command restarts the read-out from coefficient 0.

// File: rtl/fdct_pkg.sv
package fdct_pkg;

    localparam int SIDE      = 8;
    localparam int NPIX      = SIDE * SIDE;
    localparam int AXIS_W    = $clog2(SIDE);
    localparam int IDX_W     = $clog2(NPIX);
    localparam int COS_W     = 8;
    localparam int FRAC      = 6;
    localparam int INV_SQRT2 = 45;
    localparam int QTR_SH    = 2;

    // cos(k*pi/16) * 64, rounded, first quadrant (k = 0..8)
    function automatic logic signed [COS_W-1:0] cos_base(input logic [3:0] k);
        logic signed [COS_W-1:0] r;
        case (k)
            4'd0:    r = 8'sd64;
            4'd1:    r = 8'sd63;
            4'd2:    r = 8'sd59;
            4'd3:    r = 8'sd53;
            4'd4:    r = 8'sd45;
            4'd5:    r = 8'sd36;
            4'd6:    r = 8'sd24;
            4'd7:    r = 8'sd12;
            default: r = 8'sd0;
        endcase
        return r;
    endfunction

    // cos((2s+1)*f*pi/16) in the same format, folded by symmetry over k mod 32
    function automatic logic signed [COS_W-1:0] cos_entry(input logic [AXIS_W-1:0] s,
                                                          input logic [AXIS_W-1:0] f);
        logic [7:0] prod;
        logic [4:0] m;
        logic [4:0] k;
        logic       neg;
        prod = 8'({s, 1'b1}) * 8'(f);
        m    = prod[4:0];
        if (m <= 5'd8) begin
            k = m;            neg = 1'b0;
        end else if (m <= 5'd16) begin
            k = 5'd16 - m;    neg = 1'b1;
        end else if (m <= 5'd24) begin
            k = m - 5'd16;    neg = 1'b1;
        end else begin
            k = 5'd0 - m;     neg = 1'b0;   // 32 - m modulo 32
        end
        return neg ? -cos_base(k[3:0]) : cos_base(k[3:0]);
    endfunction

endpackage

// File: rtl/fdct_cos_rom.sv
module fdct_cos_rom
    import fdct_pkg::*;
(
    input  logic [AXIS_W-1:0]       spat,
    input  logic [AXIS_W-1:0]       freq,
    output logic signed [COS_W-1:0] coef
);

    always_comb begin
        coef = cos_entry(spat, freq);
    end

endmodule

// File: rtl/fdct_term.sv
module fdct_term
    import fdct_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TERM_W = 12
) (
    input  logic signed [DATA_W-1:0] pix,
    input  logic signed [COS_W-1:0]  cos_a,
    input  logic signed [COS_W-1:0]  cos_b,
    output logic signed [TERM_W-1:0] term
);

    localparam int P1_W   = DATA_W + COS_W;
    localparam int P2_W   = P1_W + COS_W;
    localparam int LIM_HI = 2 ** (DATA_W - 1) - 1;
    localparam int LIM_LO = -(2 ** (DATA_W - 1));

    logic signed [P1_W-1:0] p1_d;
    logic signed [P1_W-1:0] s1_d;
    logic signed [P2_W-1:0] p2_d;
    logic signed [P2_W-1:0] s2_d;

    always_comb begin
        p1_d = pix * cos_a;
        s1_d = p1_d >>> FRAC;
        p2_d = s1_d * cos_b;
        s2_d = p2_d >>> FRAC;
        term = s2_d[TERM_W-1:0];
    end

    // R6: with table magnitudes at most 64, a term never leaves the sample range
    always_comb begin
        a_r6_term_range: assert (s2_d >= LIM_LO && s2_d <= LIM_HI)
            else $error("term out of range");
    end

endmodule

// File: rtl/fdct_scale.sv
module fdct_scale
    import fdct_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int DATA_W = 8
) (
    input  logic signed [ACC_W-1:0]  sum,
    input  logic                     dc_row,
    input  logic                     dc_col,
    output logic signed [DATA_W-1:0] coef
);

    localparam int W = ACC_W + 8;
    localparam logic signed [W-1:0] KINV = W'(INV_SQRT2);
    localparam logic signed [W-1:0] HI   = W'(2 ** (DATA_W - 1) - 1);
    localparam logic signed [W-1:0] LO   = -HI - W'(1);

    logic signed [W-1:0] a0_d, a1_d, a2_d, a3_d;

    always_comb begin
        a0_d = {{(W - ACC_W){sum[ACC_W-1]}}, sum};
        a1_d = dc_row ? ((a0_d * KINV) >>> FRAC) : a0_d;
        a2_d = dc_col ? ((a1_d * KINV) >>> FRAC) : a1_d;
        a3_d = a2_d >>> QTR_SH;
        if (a3_d > HI)      coef = HI[DATA_W-1:0];
        else if (a3_d < LO) coef = LO[DATA_W-1:0];
        else                coef = a3_d[DATA_W-1:0];
    end

endmodule

// File: rtl/fdct_copro.sv
module fdct_copro
    import fdct_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int ACC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
    localparam int TERM_W  = DATA_W + 4;
    localparam int RUN_LEN = NPIX * NPIX;
    localparam int CNT_W   = $clog2(RUN_LEN) + 1;

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic [IDX_W-1:0]        push;
        logic [IDX_W-1:0]        pop;
        logic [IDX_W-1:0]        oidx;
        logic [IDX_W-1:0]        tidx;
        logic signed [ACC_W-1:0] acc;
        logic [DATA_W-1:0]       rdata;
    } ctl_t;

    ctl_t q, d;

    logic signed [DATA_W-1:0] ibuf [NPIX];
    logic signed [DATA_W-1:0] obuf [NPIX];

    logic                     ibuf_we, obuf_we;
    logic signed [COS_W-1:0]  cos_xu, cos_yv;
    logic signed [TERM_W-1:0] term;
    logic signed [ACC_W-1:0]  acc_sum;
    logic signed [DATA_W-1:0] coef;

    // ---- arithmetic datapath ----
    fdct_cos_rom u_cos_row (
        .spat (q.tidx[IDX_W-1:AXIS_W]),
        .freq (q.oidx[IDX_W-1:AXIS_W]),
        .coef (cos_xu)
    );

    fdct_cos_rom u_cos_col (
        .spat (q.tidx[AXIS_W-1:0]),
        .freq (q.oidx[AXIS_W-1:0]),
        .coef (cos_yv)
    );

    fdct_term #(.DATA_W(DATA_W), .TERM_W(TERM_W)) u_term (
        .pix   (ibuf[q.tidx]),
        .cos_a (cos_xu),
        .cos_b (cos_yv),
        .term  (term)
    );

    always_comb begin
        acc_sum = q.acc + {{(ACC_W - TERM_W){term[TERM_W-1]}}, term};
    end

    fdct_scale #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_scale (
        .sum    (acc_sum),
        .dc_row (q.oidx[IDX_W-1:AXIS_W] == '0),
        .dc_col (q.oidx[AXIS_W-1:0] == '0),
        .coef   (coef)
    );

    // ---- next-state ----
    always_comb begin
        d       = q;
        ibuf_we = 1'b0;
        obuf_we = 1'b0;

        if (q.busy) begin
            d.tidx = q.tidx + 1'b1;
            if (q.tidx == '1) begin
                obuf_we = 1'b1;
                d.acc   = '0;
                d.oidx  = q.oidx + 1'b1;
                if (q.oidx == '1) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end else begin
                d.acc = acc_sum;
            end
        end

        if (bus_rd) begin
            case (bus_addr)
                A_DOUT: begin
                    d.rdata = obuf[q.pop];
                    d.pop   = q.pop + 1'b1;
                end
                A_STAT:  d.rdata = {{(DATA_W - 2){1'b0}}, q.busy, q.done};
                default: d.rdata = '0;
            endcase
        end

        if (bus_wr && !q.busy) begin
            if (bus_addr == A_DIN) begin
                ibuf_we = 1'b1;
                d.push  = q.push + 1'b1;
            end else if (bus_addr == A_CMD && bus_wdata[0]) begin
                d.busy = 1'b1;
                d.done = 1'b0;
                d.push = '0;
                d.pop  = '0;
                d.oidx = '0;
                d.tidx = '0;
                d.acc  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (ibuf_we) ibuf[q.push] <= bus_wdata;
        if (obuf_we) obuf[q.oidx] <= coef;
    end

    assign bus_rdata = q.rdata;

    // ---- assertions ----
    logic [CNT_W-1:0] run_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_cnt_q <= '0;
        else if (q.busy) run_cnt_q <= run_cnt_q + 1'b1;
        else             run_cnt_q <= '0;
    end

    a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.busy && q.done));

    // R4 and R11: an accepted start clears both positions
    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD && bus_wdata[0] && !q.busy)
        |=> (q.busy && !q.done && q.pop == '0 && q.push == '0));

    a_r4_zero_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD && !bus_wdata[0] && !q.busy) |=> !q.busy);

    a_r9_run_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (run_cnt_q == CNT_W'(RUN_LEN) && q.done));

    a_r10_push_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && bus_wr && bus_addr == A_DIN) |=> $stable(q.push));

endmodule

// File: tb/sim_fdct_copro.sv
`timescale 1ns/1ps
module sim_fdct_copro;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    always #2.5 clk = ~clk;

    fdct_copro u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_q[$];
    string tag_q[$];
    logic chk_q = 1'b0;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        chk_q <= bus_rd && (bus_addr == 2'd1);
    end

    // scoreboard monitor: compare each data-out read with the queued expectation
    always @(negedge clk) begin
        if (chk_q) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected coefficient read, actual %0d expected none",
                         $signed(bus_rdata));
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (int'($signed(bus_rdata)) != e) begin
                    bad++;
                    $display("FAIL %s coefficient actual %0d expected %0d", t,
                             $signed(bus_rdata), e);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    function automatic int cos_fx(input int s, input int f);
        real r;
        r = 64.0 * $cos(real'((2 * s + 1) * f) * 3.14159265358979 / 16.0);
        return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
    endfunction

    task automatic model(input int px[64], output int res[64]);
        for (int u = 0; u < 8; u++) begin
            for (int v = 0; v < 8; v++) begin
                int s;
                s = 0;
                for (int x = 0; x < 8; x++) begin
                    for (int y = 0; y < 8; y++) begin
                        int p;
                        p = (px[x * 8 + y] * cos_fx(x, u)) >>> 6;
                        s += (p * cos_fx(y, v)) >>> 6;
                    end
                end
                if (u == 0) s = (s * 45) >>> 6;
                if (v == 0) s = (s * 45) >>> 6;
                s = s >>> 2;
                if (s > 127) s = 127;
                if (s < -128) s = -128;
                res[u * 8 + v] = s;
            end
        end
    endtask

    task automatic push_block(input int px[64]);
        for (int i = 0; i < 64; i++) bus_write(2'd0, px[i][7:0]);
    endtask

    task automatic wait_done();
        logic [7:0] st;
        int n;
        n = 0;
        st = '0;
        while (!st[0] && n < 6000) begin
            bus_read(2'd3, st);
            n++;
        end
        check(st == 8'h01, "R9 done after run", int'(st), 1);
    endtask

    task automatic drain(input int res[64], input int cnt, input string tag);
        logic [7:0] v;
        for (int i = 0; i < cnt; i++) begin
            exp_q.push_back(res[i]);
            tag_q.push_back(tag);
            bus_read(2'd1, v);
        end
    endtask

    task automatic run_block(input int px[64], input string tag);
        int res[64];
        model(px, res);
        push_block(px);
        bus_write(2'd2, 8'h01);
        wait_done();
        drain(res, 64, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired, actual running expected finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int px[64];
        int px2[64];
        int res[64];
        int c0;
        int lcg;
        logic [7:0] v;

        repeat (3) @(negedge clk);
        check(bus_rdata == 8'h00, "R1 rdata after reset", int'(bus_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(2'd3, v);
        check(v == 8'h00, "R1 status after reset", int'(v), 0);

        // R2: unreadable offset returns 0; read data holds
        bus_read(2'd0, v);
        check(v == 8'h00, "R2 read of data-in offset", int'(v), 0);

        // R6 all-zero block
        for (int i = 0; i < 64; i++) px[i] = 0;
        run_block(px, "R6 zero block");

        // R2 hold after status read (done = 1)
        bus_read(2'd3, v);
        repeat (3) @(negedge clk);
        check(bus_rdata == 8'h01, "R2 rdata holds", int'(bus_rdata), 1);

        // R8 saturation, both signs
        for (int i = 0; i < 64; i++) px[i] = 127;
        run_block(px, "R8 R7 positive clamp");
        for (int i = 0; i < 64; i++) px[i] = -128;
        run_block(px, "R8 R7 negative clamp");

        // R5 single impulse exposes table products
        for (int i = 0; i < 64; i++) px[i] = 0;
        px[3 * 8 + 5] = 100;
        run_block(px, "R5 impulse");

        // R3 R6 R7 pseudo-random block
        lcg = 12345;
        for (int i = 0; i < 64; i++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            px[i] = ((lcg >>> 16) & 255) - 128;
        end
        run_block(px, "R3 R6 R7 random");

        // R4 zero command ignored
        bus_write(2'd2, 8'h00);
        bus_read(2'd3, v);
        check(v == 8'h01, "R4 zero command no effect", int'(v), 1);

        // R9 exact timing, R4 command while busy, R10 pushes while busy
        for (int i = 0; i < 64; i++) px2[i] = ((i * 37) % 200) - 100;
        model(px2, res);
        push_block(px2);
        bus_write(2'd2, 8'h01);
        c0 = cyc;
        bus_read(2'd3, v);
        check(v == 8'h02, "R4 busy after start", int'(v), 2);
        for (int i = 0; i < 5; i++) bus_write(2'd0, 8'h55);
        bus_write(2'd2, 8'h01);
        while (cyc < c0 + 4095) @(negedge clk);
        bus_read(2'd3, v);
        check(v == 8'h02, "R9 still busy at last cycle", int'(v), 2);
        bus_read(2'd3, v);
        check(v == 8'h01, "R9 done right after run", int'(v), 1);
        drain(res, 10, "R10 R4 block after ignored writes");

        // R11 re-command without pushes: read restarts at 0 on retained samples
        bus_write(2'd2, 8'h01);
        wait_done();
        drain(res, 64, "R11 rerun from position 0");

        // R3 push wrap: 70 writes, last 6 overwrite positions 0..5
        for (int i = 0; i < 64; i++) px[i] = (i % 7) * 9 - 27;
        push_block(px);
        for (int i = 0; i < 6; i++) begin
            px[i] = 90 - i * 30;
            bus_write(2'd0, px[i][7:0]);
        end
        model(px, res);
        bus_write(2'd2, 8'h01);
        wait_done();
        drain(res, 64, "R3 push wrap");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R11 all expected read", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule